// File: doc/BRIEF.md
# Paired-Register I2C Write Slave

This block is an I2C target that only accepts writes. It fills a bank of twelve 8-bit control registers, numbered 2 to 13. The transfer carries no separate sub-address byte. Instead, the leading bits of the first data byte after the address pick an even/odd register pair. That whole byte, selector bits included, is stored in the even register of the pair. Each later byte in the same transfer lands in the next register number, and the transfer can run across pair boundaries. Once register 13 has been written, any further bytes are acknowledged and then dropped.

SCL and SDA are brought into the system clock domain through a flop synchroniser. Start and stop conditions are found as SDA edges seen while SCL is high, and data bits are taken on the rising edge of SCL. The block pulls SDA low through an open-drain enable, and only during acknowledge slots. All twelve registers are always visible on one flat parallel output. A write updates only the registers it reaches, so a host can rewrite any pair at any time in any order.

Top module: `pairwr_i2c_slave`

## Requirements
- R1: After reset every register reads 0x00 and the SDA pull-down enable is off.
- R2: The address byte is acknowledged only when its upper seven bits equal the device address and its LSB (direction bit) is 0. Otherwise nothing is acknowledged and no register changes until the next start condition.
- R3: The first data byte of a transfer selects the even register by its leading bits: 0xxxxxxx gives 2, 10xxxxxx gives 4, 1100xxxx gives 6, 1101xxxx gives 8, 1110xxxx gives 10, 1111xxxx gives 12.
- R4: The full first data byte, selector bits included, is stored in the selected even register.
- R5: Each following data byte is stored in the next higher register number, continuing across pair boundaries.
- R6: Data bytes that arrive after register 13 has been written are acknowledged but not stored.
- R7: In an addressed write, every data byte receives an acknowledge: SDA is pulled low during the ninth clock.
- R8: Registers that a transfer does not reach keep their values, and pairs may be written in any order across transfers.
- R9: A repeated start restarts the transfer, so the first data byte after the new address is decoded as a pair selector again.
- R10: The SDA pull-down enable changes only while SCL is low.

Register n appears on `regs_flat[(n-2)*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| regs_flat | output | 96 | Registers 2..13, register 2 in the lowest byte |

## Verification
The assertions rely on the master changing SDA only while SCL is low, except for start and stop conditions. They also rely on SCL staying low for several system clocks, so that the pull-down enable has settled before SCL rises again. The bench drives the bus at a quarter-bit spacing of many clock cycles, on the falling clock edge, and models the open-drain line as the AND of master and slave. This keeps the synchronised view clean and keeps every SDA change by either side inside an SCL-low window.

// File: rtl/pairwr_pkg.sv
// Shared definitions for the paired-register I2C write slave.
// Assumes the pair selector always sits in the top bits of an 8-bit byte.
package pairwr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK,
        RX_IGNORE
    } rx_state_t;

    // Map the leading selector bits of a byte to the array index of the even register
    function automatic logic [3:0] pair_base(input logic [7:0] sel);
        if (!sel[7])                 return 4'd0;   // register 2
        else if (!sel[6])            return 4'd2;   // register 4
        else if (sel[5:4] == 2'b00)  return 4'd4;   // register 6
        else if (sel[5:4] == 2'b01)  return 4'd6;   // register 8
        else if (sel[5:4] == 2'b10)  return 4'd8;   // register 10
        else                         return 4'd10;  // register 12
    endfunction

endpackage

// File: rtl/pairwr_line_sync.sv
// Brings SCL/SDA into the system clock domain and detects bus events.
// Assumes lines idle high; all event outputs are single-cycle pulses.
module pairwr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains and one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
            scl_prev  <= scl_chain[STAGES-1];
            sda_prev  <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/pairwr_regbank.sv
// Bank of byte registers written one at a time by index.
// Assumes wr_idx is in range whenever wr_en is high.
module pairwr_regbank #(
    parameter int NUM_REGS = 12,
    parameter int PTR_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] value;

        // Hold one register, load it when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)                                value <= 8'h00;
            else if (wr_en && wr_idx == PTR_W'(g))     value <= wr_data;
        end

        assign regs_flat[g*8 +: 8] = value;
    end

endmodule

// File: rtl/pairwr_rx_fsm.sv
// Byte receiver and write sequencer for the paired-register slave.
// Assumes synchronised, glitch-free line views and pulse events.
module pairwr_rx_fsm
    import pairwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60,
    parameter int         NUM_REGS = 12,
    parameter int         PTR_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output rx_state_t        state
);

    logic [7:0]       shreg;
    logic [2:0]       bit_cnt;
    logic             byte_done;
    logic             first_byte;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] base_idx;

    assign base_idx = PTR_W'(pair_base(shreg));

    // Receive state machine: shift bits, drive acks, issue register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            byte_done  <= 1'b0;
            first_byte <= 1'b0;
            ptr        <= '0;
            sda_oe     <= 1'b0;
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state      <= RX_ADDR;
                bit_cnt    <= '0;
                byte_done  <= 1'b0;
                first_byte <= 1'b1;
                sda_oe     <= 1'b0;
            end else if (stop_det) begin
                state  <= RX_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    RX_ADDR, RX_DATA: begin
                        if (scl_rise) begin
                            shreg     <= {shreg[6:0], sda_s};
                            bit_cnt   <= bit_cnt + 3'd1;
                            byte_done <= (bit_cnt == 3'd7);
                        end else if (scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            if (state == RX_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                                    sda_oe <= 1'b1;
                                    state  <= RX_ADDR_ACK;
                                end else begin
                                    state  <= RX_IGNORE;
                                end
                            end else begin
                                sda_oe  <= 1'b1;
                                state   <= RX_DATA_ACK;
                                wr_data <= shreg;
                                if (first_byte) begin
                                    first_byte <= 1'b0;
                                    wr_en      <= 1'b1;
                                    wr_idx     <= base_idx;
                                    ptr        <= base_idx + 1'b1;
                                end else if (ptr < PTR_W'(NUM_REGS)) begin
                                    wr_en  <= 1'b1;
                                    wr_idx <= ptr;
                                    ptr    <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    RX_ADDR_ACK, RX_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= RX_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pairwr_i2c_slave.sv
// Top of the paired-register I2C write slave: sync, receiver, register bank.
// Assumes an external open-drain pad; sda_oe=1 pulls the line low.
module pairwr_i2c_slave
    import pairwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter int         NUM_REGS    = 12,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(NUM_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    rx_state_t        state;
    logic             st_ignore;
    logic             st_ack;

    pairwr_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    pairwr_rx_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .state(state)
    );

    pairwr_regbank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    assign st_ignore = (state == RX_IGNORE);
    assign st_ack    = (state == RX_ADDR_ACK) || (state == RX_DATA_ACK);

endmodule

// File: rtl/pairwr_checker.sv
// Protocol checks for the paired-register I2C write slave, bound to the top.
// Assumes the master only moves SDA while SCL is low, except for start/stop.
module pairwr_checker #(
    parameter int NUM_REGS = 12,
    parameter int PTR_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_idx,
    input logic             ignoring,
    input logic             ack_slot
);

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_s); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> wr_idx < PTR_W'(NUM_REGS)); // R6
    AST_ONE_WRITE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R5
    AST_NO_WRITE_UNMATCHED: assert property (@(posedge clk) disable iff (!rst_n) ignoring |-> !wr_en && !sda_oe); // R2
    AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n) sda_oe |-> ack_slot); // R7

endmodule

bind pairwr_i2c_slave pairwr_checker #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .wr_en(wr_en),
    .wr_idx(wr_idx), .ignoring(st_ignore), .ack_slot(st_ack)
);

// File: tb/pairwr_i2c_slave_tb_top.sv
// Directed bench for the paired-register I2C write slave.
module pairwr_i2c_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 20;
    localparam int NREG       = 12;
    localparam int WDOG_LIMIT = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_scl = 1'b1;
    logic            m_sda_low = 1'b0;
    logic            sda_oe;
    logic [NREG*8-1:0] regs_flat;
    logic            sda_line;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [NREG];
    logic [7:0] tx_buf [8];
    logic [7:0] ack_bits;

    assign sda_line = ~(m_sda_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    pairwr_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .regs_flat(regs_flat)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(string req);
        for (int i = 0; i < NREG; i++) chk(req, regs_flat[i*8 +: 8], model[i]);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_q();
        m_scl = 1'b1;     wait_q();
        m_sda_low = 1'b1; wait_q();
        m_scl = 1'b0;     wait_q();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_q();
        m_scl = 1'b1;     wait_q();
        m_sda_low = 1'b0; wait_q();
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; wait_q();
            m_scl = 1'b1;      wait_q(); wait_q();
            m_scl = 1'b0;      wait_q();
        end
        m_sda_low = 1'b0; wait_q();
        m_scl = 1'b1;     wait_q();
        ack = ~sda_line;  wait_q();
        m_scl = 1'b0;     wait_q();
    endtask

    // Start, then n bytes from tx_buf; acks collected in ack_bits
    task automatic run_xfer(input int n, input bit do_stop);
        logic a;
        ack_bits = '0;
        bus_start();
        for (int i = 0; i < n; i++) begin
            send_byte(tx_buf[i], a);
            ack_bits[i] = a;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic t_reset();
        chk_regs("R1");
        chk("R1", {7'd0, sda_oe}, 8'h00);
    endtask

    // Each selector on its own, in scrambled pair order
    task automatic t_selectors();
        logic [7:0] sel [6] = '{8'hE1, 8'h9A, 8'h35, 8'hF8, 8'hC7, 8'hD3};
        int         base [6] = '{8, 2, 0, 10, 4, 6};
        for (int k = 0; k < 6; k++) begin
            tx_buf[0] = 8'hC0; tx_buf[1] = sel[k]; tx_buf[2] = 8'h40 + 8'(k);
            run_xfer(3, 1'b1);
            model[base[k]]     = sel[k];
            model[base[k] + 1] = 8'h40 + 8'(k);
            chk("R2", {7'd0, ack_bits[0]}, 8'h01);
            chk("R7", ack_bits & 8'h06, 8'h06);
            chk_regs("R3_R4_R8");
        end
    endtask

    task automatic t_continue();
        tx_buf[0] = 8'hC0; tx_buf[1] = 8'hC4;
        for (int i = 2; i < 7; i++) tx_buf[i] = 8'hA0 + 8'(i);
        run_xfer(7, 1'b1);
        model[4] = 8'hC4;
        for (int i = 2; i < 7; i++) model[3 + i] = 8'hA0 + 8'(i);
        chk("R7", ack_bits, 8'h7F);
        chk_regs("R5");
    endtask

    task automatic t_overflow();
        tx_buf[0] = 8'hC0; tx_buf[1] = 8'hF2; tx_buf[2] = 8'h5C;
        tx_buf[3] = 8'h77; tx_buf[4] = 8'h88;
        run_xfer(5, 1'b1);
        model[10] = 8'hF2; model[11] = 8'h5C;
        chk("R6", ack_bits, 8'h1F);
        chk_regs("R6");
    endtask

    task automatic t_bad_addr();
        tx_buf[0] = 8'hC2; tx_buf[1] = 8'h00; tx_buf[2] = 8'hFF;
        run_xfer(3, 1'b1);
        chk("R2", ack_bits, 8'h00);
        chk_regs("R2");
        tx_buf[0] = 8'hC1; tx_buf[1] = 8'h12;
        run_xfer(2, 1'b1);
        chk("R2", ack_bits, 8'h00);
        chk_regs("R2");
    endtask

    task automatic t_rstart();
        tx_buf[0] = 8'hC0; tx_buf[1] = 8'h11;
        run_xfer(2, 1'b0);
        model[0] = 8'h11;
        tx_buf[0] = 8'hC0; tx_buf[1] = 8'hE5; tx_buf[2] = 8'h66;
        run_xfer(3, 1'b1);
        model[8] = 8'hE5; model[9] = 8'h66;
        chk("R9", ack_bits, 8'h07);
        chk_regs("R9");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_selectors();
        t_continue();
        t_overflow();
        t_bad_addr();
        t_rstart();
        finish_run();
    end

endmodule